// File: doc/BRIEF.md
# Projector power and LED enable sequencer

This block times the power and light-source enables of a light-modulator display controller. It samples three asynchronous pins: an active-low power-on reset, an active-low park request and an active-high LED enable. The park and LED enable pins each pass through a two-flop synchroniser. The reset pin is synchronised into an internal synchronous reset. All delays are counted in clock cycles, and each delay length is a parameter. The defaults give 100 ms and 500 us at a 250 MHz clock. A bench can shrink them.

The two main enables behave in opposite ways. The modulator power enable follows park high at once. When park drops, the power enable stays high for a hold period. The LED driver master enable waits until the LED enable has been high for a full qualification period. It drops at once when either the LED enable or park goes low. The two-bit LED select passes an upstream colour code through only while the LED master path is qualified; otherwise it is forced to "no LED". A strap pin is captured once at reset release and chooses between two 7-bit bus slave addresses. A bus-ready flag shows that a quiet period has passed since park went high out of reset. While reset is asserted, each driven output has its own output-enable held low.

Top module: `lgt_pwr_led_seq`

## Requirements
- R1: With park high and out of reset, `led_on_o` rises on the (LED_QUAL_CYC+3)-th rising clock edge after `led_en_i` goes high, and not earlier.
- R2: `led_on_o` falls on the 3rd rising edge after either `led_en_i` or `park_n_i` goes low, with no qualification delay, and it is never high while `pwr_en_o` is low.
- R3: If `led_en_i` falls before qualification completes, `led_on_o` stays low, and the next rise of `led_en_i` needs the full LED_QUAL_CYC count again.
- R4: `led_sel_o` is 2'b00 ("no LED") unless the LED enable is qualified. Once qualified, it registers `led_color_i` with one edge of latency. The encoding is 00 none, 01 red, 10 green, 11 blue.
- R5: `pwr_en_o` rises on the 3rd rising edge after `park_n_i` goes high.
- R6: After `park_n_i` goes low, `pwr_en_o` stays high through edge PWR_HOLD_CYC+2 and falls on edge PWR_HOLD_CYC+3.
- R7: If `park_n_i` returns high during the hold, `pwr_en_o` never falls, and the next park request starts a full new hold.
- R8: On the 3rd rising edge after `rst_n_i` goes high, the strap is captured: low gives `slave_addr_o` = 7'h1B and high gives 7'h1D. Later strap changes have no effect until the next reset.
- R9: `bus_ready_o` rises on edge BUS_QUIET_CYC+3 after `park_n_i` goes high out of reset, and it falls on the 3rd edge after park goes low.
- R10: From the 3rd rising edge after `rst_n_i` goes low, all three output-enables are 0 and `pwr_en_o`, `led_on_o`, `led_sel_o` and `bus_ready_o` are 0. The output-enables return to 1 on the 3rd edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous power-on reset, active low |
| park_n_i | input | 1 | Park request, active low (high = run) |
| led_en_i | input | 1 | LED enable request, active high |
| addr_strap_i | input | 1 | Address strap, sampled at reset release |
| led_color_i | input | 2 | Colour code from the upstream sequencer |
| pwr_en_o | output | 1 | Modulator power-regulator enable |
| pwr_oe_o | output | 1 | Output-enable for `pwr_en_o` |
| led_on_o | output | 1 | LED driver master enable |
| led_on_oe_o | output | 1 | Output-enable for `led_on_o` |
| led_sel_o | output | 2 | LED colour select |
| led_sel_oe_o | output | 1 | Output-enable for `led_sel_o` |
| slave_addr_o | output | 7 | Selected 7-bit bus slave address |
| bus_ready_o | output | 1 | Post-park quiet period elapsed |

## Verification
Every pin-to-output path has a fixed latency. Two synchroniser flops and one output register give three edges, and the qualifying or hold count adds its length on top. The exception is the select, which registers the colour code directly with one edge of latency. The bench drives inputs 1 ns after a rising edge, counts edges from there and samples 1 ns after the edge in question. Around each transition it checks the edge just before the expected change and the edge where the change is due, so a result off by one cycle in either direction is caught. The abort and park re-raise cases are swept over every offset inside their windows.

// File: rtl/lgt_seq_pkg.sv
package lgt_seq_pkg;

  localparam int unsigned ADDR_W = 7;

  // Delay-gate flavours: qualify-on (slow rise, fast fall) or hold-off
  // (fast rise, slow fall).
  typedef enum logic {
    GATE_ON_DELAY  = 1'b0,
    GATE_OFF_DELAY = 1'b1
  } gate_mode_e;

  typedef enum logic [1:0] {
    LED_NONE  = 2'b00,
    LED_RED   = 2'b01,
    LED_GREEN = 2'b10,
    LED_BLUE  = 2'b11
  } led_color_e;

  typedef enum int unsigned {
    OE_PWR = 0,
    OE_LED = 1,
    OE_SEL = 2,
    OE_NUM = 3
  } oe_idx_e;

endpackage

// File: rtl/lgt_sync2.sv
module lgt_sync2 #(
  parameter int unsigned      WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q = RST_VAL;
  logic [WIDTH-1:0] sync_q = RST_VAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/lgt_delay_gate.sv
module lgt_delay_gate #(
  parameter lgt_seq_pkg::gate_mode_e MODE   = lgt_seq_pkg::GATE_ON_DELAY,
  parameter int unsigned             CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_i,
  output logic out_o
);
  import lgt_seq_pkg::*;

  localparam int unsigned   CW    = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q = '0;
  logic          out_q = 1'b0;

  generate
    if (MODE == GATE_ON_DELAY) begin : g_on
      // Output rises after CYCLES consecutive high samples; any low sample
      // clears both the count and the output.
      always_ff @(posedge clk) begin
        if (rst || !in_i) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else if (cnt_q != LIMIT) begin
          cnt_q <= cnt_q + 1'b1;
          out_q <= (cnt_q == LIMIT - 1'b1);
        end
      end
    end else begin : g_off
      // Output follows a high sample at once; after the input goes low it
      // is kept for CYCLES further samples. A high sample clears the count.
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else if (in_i) begin
          cnt_q <= '0;
          out_q <= 1'b1;
        end else if (out_q) begin
          if (cnt_q == LIMIT) begin
            cnt_q <= '0;
            out_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign out_o = out_q;

  // R1 / R6: the counter never runs past its limit.
  p_count_capped_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

endmodule

// File: rtl/lgt_addr_strap.sv
module lgt_addr_strap #(
  parameter logic [lgt_seq_pkg::ADDR_W-1:0] ADDR_LO = 7'h1B,
  parameter logic [lgt_seq_pkg::ADDR_W-1:0] ADDR_HI = 7'h1D
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           strap_i,
  output logic [lgt_seq_pkg::ADDR_W-1:0] addr_o
);

  logic was_rst_q = 1'b1;
  logic hi_q      = 1'b0;

  always_ff @(posedge clk) begin
    was_rst_q <= rst;
    if (rst) begin
      hi_q <= 1'b0;
    end else if (was_rst_q) begin
      hi_q <= strap_i;     // single capture on the first edge out of reset
    end
  end

  assign addr_o = hi_q ? ADDR_HI : ADDR_LO;

  // R8: once captured, the address does not move until the next reset.
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !was_rst_q |=> $stable(addr_o));

endmodule

// File: rtl/lgt_pwr_led_seq.sv
module lgt_pwr_led_seq #(
  parameter int unsigned LED_QUAL_CYC  = 25_000_000,
  parameter int unsigned PWR_HOLD_CYC  = 125_000,
  parameter int unsigned BUS_QUIET_CYC = 25_000_000,
  parameter logic [6:0]  ADDR_LO       = 7'h1B,
  parameter logic [6:0]  ADDR_HI       = 7'h1D
) (
  input  logic       clk,
  input  logic       rst_n_i,
  input  logic       park_n_i,
  input  logic       led_en_i,
  input  logic       addr_strap_i,
  input  logic [1:0] led_color_i,
  output logic       pwr_en_o,
  output logic       pwr_oe_o,
  output logic       led_on_o,
  output logic       led_on_oe_o,
  output logic [1:0] led_sel_o,
  output logic       led_sel_oe_o,
  output logic [6:0] slave_addr_o,
  output logic       bus_ready_o
);
  import lgt_seq_pkg::*;

  localparam int unsigned NUM_OE = int'(OE_NUM);

  logic       rst_n_s;
  logic       rst;
  logic       park_s;
  logic       led_s;
  logic       led_qual;
  logic       pwr_hold;
  logic       bus_qual;

  logic              led_on_q = 1'b0;
  logic [1:0]        sel_q    = LED_NONE;
  logic              ready_q  = 1'b0;
  logic [NUM_OE-1:0] oe_q     = '0;

  // Reset pin: synchronised, no reset of its own, starts in reset.
  lgt_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk (clk),
    .rst (1'b0),
    .d_i (rst_n_i),
    .q_o (rst_n_s)
  );
  assign rst = ~rst_n_s;

  // Park and LED enable synchronisers, cleared by the internal reset.
  lgt_sync2 #(.WIDTH(2), .RST_VAL(2'b00)) u_in_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({park_n_i, led_en_i}),
    .q_o ({park_s, led_s})
  );

  lgt_delay_gate #(.MODE(GATE_ON_DELAY), .CYCLES(LED_QUAL_CYC)) u_led_qual (
    .clk   (clk),
    .rst   (rst),
    .in_i  (led_s),
    .out_o (led_qual)
  );

  lgt_delay_gate #(.MODE(GATE_OFF_DELAY), .CYCLES(PWR_HOLD_CYC)) u_pwr_hold (
    .clk   (clk),
    .rst   (rst),
    .in_i  (park_s),
    .out_o (pwr_hold)
  );

  lgt_delay_gate #(.MODE(GATE_ON_DELAY), .CYCLES(BUS_QUIET_CYC)) u_bus_quiet (
    .clk   (clk),
    .rst   (rst),
    .in_i  (park_s),
    .out_o (bus_qual)
  );

  lgt_addr_strap #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .strap_i (addr_strap_i),
    .addr_o  (slave_addr_o)
  );

  // Output gating: qualification counts only on the rise; any low
  // synchronised request clears the output on the next edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      led_on_q <= 1'b0;
      sel_q    <= LED_NONE;
      ready_q  <= 1'b0;
    end else begin
      led_on_q <= led_qual & led_s & park_s;
      sel_q    <= (led_qual & led_s) ? led_color_i : LED_NONE;
      ready_q  <= bus_qual & park_s;
    end
  end

  generate
    for (genvar g = 0; g < NUM_OE; g++) begin : g_oe
      always_ff @(posedge clk) begin
        oe_q[g] <= ~rst;
      end
    end
  endgenerate

  assign pwr_en_o     = pwr_hold;
  assign pwr_oe_o     = oe_q[OE_PWR];
  assign led_on_o     = led_on_q;
  assign led_on_oe_o  = oe_q[OE_LED];
  assign led_sel_o    = sel_q;
  assign led_sel_oe_o = oe_q[OE_SEL];
  assign bus_ready_o  = ready_q;

  // R1: the LED master enable only rises after the qualifier completed.
  p_led_needs_qual_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(led_on_q) |-> $past(led_qual));

  // R2: the LED master enable is never on without modulator power.
  p_led_under_power_r2: assert property (@(posedge clk) disable iff (rst)
    led_on_q |-> pwr_hold);

  // R4: a non-zero select needs a high LED enable on the prior edge.
  p_sel_forced_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_q != LED_NONE) |-> $past(led_s));

  // R5: a synchronised run request turns the power on by the next edge.
  p_pwr_follows_park_r5: assert property (@(posedge clk) disable iff (rst)
    park_s |=> pwr_hold);

  // R6: the power enable only falls while park is being requested.
  p_pwr_falls_parked_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_hold) |-> $past(!park_s));

  // R9: bus ready implies the synchronised run request on the prior edge.
  p_ready_needs_park_r9: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> $past(park_s));

  // R10: while output-enables are low, every driven output is quiet.
  p_quiet_undriven_r10: assert property (@(posedge clk)
    !oe_q[OE_PWR] |-> (!pwr_hold && !led_on_q && sel_q == LED_NONE && !ready_q));

endmodule

// File: tb/lgt_pwr_led_seq_bench.sv
`timescale 1ns/1ps
module lgt_pwr_led_seq_bench;

  localparam int unsigned LQ = 20;
  localparam int unsigned PH = 12;
  localparam int unsigned BQ = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       park_n = 1'b0;
  logic       led_en = 1'b0;
  logic       strap = 1'b0;
  logic [1:0] color = 2'b01;
  logic       pwr, pwr_oe, led_on, led_oe, sel_oe, ready;
  logic [1:0] sel;
  logic [6:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lgt_pwr_led_seq #(
    .LED_QUAL_CYC(LQ), .PWR_HOLD_CYC(PH), .BUS_QUIET_CYC(BQ),
    .ADDR_LO(7'h1B), .ADDR_HI(7'h1D)
  ) u_lgt_pwr_led_seq (
    .clk(clk), .rst_n_i(rst_n), .park_n_i(park_n), .led_en_i(led_en),
    .addr_strap_i(strap), .led_color_i(color),
    .pwr_en_o(pwr), .pwr_oe_o(pwr_oe), .led_on_o(led_on), .led_on_oe_o(led_oe),
    .led_sel_o(sel), .led_sel_oe_o(sel_oe), .slave_addr_o(addr),
    .bus_ready_o(ready)
  );

  // Advance n rising edges and land 1 ns after the last one.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    step(5);
    // R10: reset state
    check("R10", {29'd0, pwr_oe, led_oe, sel_oe}, 32'd0);
    check("R10", {28'd0, pwr, led_on, sel == 2'b00, ready}, 32'h2);

    // R8: strap capture for both strap values, later changes ignored
    for (int s = 0; s < 2; s++) begin
      rst_n = 1'b0;
      step(4);
      strap = s[0];
      rst_n = 1'b1;
      step(2);
      check("R10", {31'd0, pwr_oe}, 32'd0);
      step(1);
      check("R10", {29'd0, pwr_oe, led_oe, sel_oe}, 32'h7);
      check("R8", addr, s ? 32'h1D : 32'h1B);
      strap = ~s[0];
      step(5);
      check("R8", addr, s ? 32'h1D : 32'h1B);
    end

    // R5 and R9: park released
    park_n = 1'b1;
    step(2);
    check("R5", pwr, 1'b0);
    step(1);
    check("R5", pwr, 1'b1);
    check("R9", ready, 1'b0);
    step(BQ - 1);
    check("R9", ready, 1'b0);
    step(1);
    check("R9", ready, 1'b1);

    // R1 and R4: qualification
    led_en = 1'b1;
    step(LQ + 2);
    check("R1", led_on, 1'b0);
    check("R4", sel, 2'b00);
    step(1);
    check("R1", led_on, 1'b1);
    check("R4", sel, 2'b01);
    for (int c = 0; c < 4; c++) begin
      color = c[1:0];
      step(1);
      check("R4", sel, c);
    end
    color = 2'b10;

    // R2 and R4: LED enable drop is immediate
    led_en = 1'b0;
    step(2);
    check("R2", led_on, 1'b1);
    step(1);
    check("R2", led_on, 1'b0);
    check("R4", sel, 2'b00);

    // R3: abort at every offset inside the window, then full recount
    for (int k = 1; k <= int'(LQ); k++) begin
      bit bad = 1'b0;
      led_en = 1'b1;
      for (int i = 0; i < k; i++) begin
        step(1);
        if (led_on !== 1'b0 || sel !== 2'b00) bad = 1'b1;
      end
      led_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
        step(1);
        if (led_on !== 1'b0 || sel !== 2'b00) bad = 1'b1;
      end
      check("R3", bad, 1'b0);
      led_en = 1'b1;
      step(LQ + 2);
      check("R3", led_on, 1'b0);
      step(1);
      check("R3", led_on, 1'b1);
      led_en = 1'b0;
      step(4);
    end

    // R2, R9, R6: park drop with LED qualified
    led_en = 1'b1;
    step(LQ + 3);
    check("R1", led_on, 1'b1);
    park_n = 1'b0;
    step(2);
    check("R2", {30'd0, led_on, ready}, 32'h3);
    step(1);
    check("R2", led_on, 1'b0);
    check("R9", ready, 1'b0);
    check("R6", pwr, 1'b1);
    step(PH - 1);
    check("R6", pwr, 1'b1);
    step(1);
    check("R6", pwr, 1'b0);

    // R7: park re-raised at every offset inside the hold
    park_n = 1'b1;
    step(6);
    for (int j = 1; j <= int'(PH); j++) begin
      bit bad = 1'b0;
      park_n = 1'b0;
      for (int i = 0; i < j; i++) begin
        step(1);
        if (pwr !== 1'b1) bad = 1'b1;
      end
      park_n = 1'b1;
      for (int i = 0; i < int'(PH) + 6; i++) begin
        step(1);
        if (pwr !== 1'b1) bad = 1'b1;
      end
      check("R7", bad, 1'b0);
    end
    park_n = 1'b0;
    step(PH + 2);
    check("R7", pwr, 1'b1);
    step(1);
    check("R7", pwr, 1'b0);

    // R10: reset while fully running
    park_n = 1'b1;
    step(BQ + LQ + 10);
    check("R9", ready, 1'b1);
    check("R1", led_on, 1'b1);
    rst_n = 1'b0;
    step(2);
    check("R10", {29'd0, pwr_oe, led_oe, sel_oe}, 32'h7);
    step(1);
    check("R10", {29'd0, pwr_oe, led_oe, sel_oe}, 32'd0);
    check("R10", {27'd0, pwr, led_on, sel, ready}, 32'd0);

    finished = 1'b1;
    summary();
  end

endmodule